// File: doc/BRIEF.md
# Programmable 16-bit compare/capture timer with PWM and one-pulse output

The block is a 16-bit up-counter with two compare registers, two capture inputs and one external count input. All of it is programmed over a simple register bus. A control byte selects the counter clock: the system clock divided by 2, 4 or 8, or qualified edges on the external count pin. The same byte selects the output mode, the edge polarities and the pin-enable gates. A small auxiliary register holds two output level bits and the trigger polarity of capture input 1.

Output 1 has three behaviours. In compare mode it is driven to a programmed level when the counter meets compare register 1. In PWM mode it repeats a waveform: compare register 2 sets the period and compare register 1 sets the pulse length. In one-pulse mode an edge on capture input 1 restarts the counter and opens a single pulse, which closes at compare register 1. Output 2 always follows compare register 2. Each output has a separate enable port that tells the pad logic whether the timer owns the pin. The timer function keeps running when the pin is released.

All three pins are asynchronous. Each is synchronised and edge-detected inside the block. Captures latch the counter value and set sticky flags that software clears by writing ones.

Top module: `cmp_timer16`

## Requirements
- R1: After reset, every register reads 0, both output levels are 0 and both pin-enable outputs are 0.
- R2: The control byte (address 0) holds, from bit 7 down to bit 0: output-1 pin enable, output-2 pin enable, one-pulse mode, PWM mode, clock code bit 1, clock code bit 0, capture-2 edge, external-clock edge. The two enable bits drive out1_en and out2_en directly. When an enable is 0 the output level keeps changing as its mode dictates.
- R3: A 3-bit prescaler counts system clocks from reset. The clock code selects the count tick: 00 ticks when the low two bits are all ones (÷4), 01 when bit 0 is one (÷2), 10 when all three bits are ones (÷8), and 11 on each qualified edge of ext_clk_in. On each tick the counter adds 1, wrapping from 0xFFFF to 0.
- R4: ext_clk_in, cap1_in and cap2_in pass through two flops before edge detection. A level change presented before clock edge k acts on the state at edge k+2, so the effect is visible after that edge. The polarity bit of each pin (1 = rising, 0 = falling) chooses which change counts.
- R5: On a tick where the counter equals compare 1, the compare-1 flag (status bit 2) is set. In compare mode (control bits 5:4 = 00), out1 also takes aux bit 0. On a tick where the counter equals compare 2, out2 takes aux bit 1 and the compare-2 flag (status bit 3) is set, in every mode.
- R6: In PWM mode (control bit 4 set, which wins over bit 5), a tick where the counter equals compare 2 loads 0 and drives out1 to aux bit 0. Otherwise, a tick where the counter equals compare 1 drives out1 to aux bit 1.
- R7: In one-pulse mode (bit 5 set, bit 4 clear), a qualified capture-1 edge (aux bit 2 = 1 rising, 0 falling) loads the counter with 0 and drives out1 to aux bit 0, ahead of any tick. The first later tick with the counter equal to compare 1 drives out1 to aux bit 1 and ends the pulse.
- R8: A qualified edge on capture input 1 (polarity aux bit 2) or capture input 2 (polarity control bit 1) copies the counter value held before that edge's update into capture register 1 (address 4) or 2 (address 5). It also sets status bit 0 or bit 1.
- R9: Writing the status register (address 7) clears each flag whose data bit is 1. A flag set by an event in the same cycle stays set.
- R10: Register map: 0 control (8 bits), 1 aux (3 bits), 2 compare 1, 3 compare 2, 4 capture 1, 5 capture 2, 6 counter, 7 status. Addresses 4 to 6 are read-only. Reads are combinational on bus_addr, and unused high bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| ext_clk_in | input | 1 | External count pin, asynchronous |
| cap1_in | input | 1 | Capture 1 / one-pulse trigger pin, asynchronous |
| cap2_in | input | 1 | Capture 2 pin, asynchronous |
| out1_lvl | output | 1 | Output 1 level |
| out1_en | output | 1 | Output 1 owns its pin |
| out2_lvl | output | 1 | Output 2 level |
| out2_en | output | 1 | Output 2 owns its pin |

## Verification
The assertions assume the following of the inputs:
- The three pins are at least quasi-static across a clock edge, so that the synchronisers resolve each change.
- Bus writes are single-cycle strobes.
- The stimulus holds all three pins low during reset, because the detectors start from a low history.

The bench drives every pin and bus signal a fixed delay after the rising edge, so each change is seen whole by the next edge. Before it enters PWM mode it restarts the counter with a one-pulse trigger. This keeps the count below compare 2, so the period matches occur within the run instead of after a full 16-bit wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    // register addresses
    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_AUX  = 3'd1;
    localparam logic [2:0] A_CMP1 = 3'd2;
    localparam logic [2:0] A_CMP2 = 3'd3;
    localparam logic [2:0] A_CAP1 = 3'd4;
    localparam logic [2:0] A_CAP2 = 3'd5;
    localparam logic [2:0] A_CNT  = 3'd6;
    localparam logic [2:0] A_STAT = 3'd7;

    // control byte fields
    localparam int CB_EN1   = 7;
    localparam int CB_EN2   = 6;
    localparam int CB_OPM   = 5;
    localparam int CB_PWM   = 4;
    localparam int CB_CKHI  = 3;
    localparam int CB_CKLO  = 2;
    localparam int CB_C2POL = 1;
    localparam int CB_EXPOL = 0;

    // aux fields
    localparam int AX_ACT   = 0;
    localparam int AX_IDLE  = 1;
    localparam int AX_C1POL = 2;

    // status flags
    localparam int FL_CAP1 = 0;
    localparam int FL_CAP2 = 1;
    localparam int FL_HIT1 = 2;
    localparam int FL_HIT2 = 3;

    typedef enum logic [1:0] {
        CK_DIV4 = 2'b00,
        CK_DIV2 = 2'b01,
        CK_DIV8 = 2'b10,
        CK_EXT  = 2'b11
    } clk_sel_e;

    // pin index for the synchroniser array
    localparam int PIN_EXT  = 0;
    localparam int PIN_CAP1 = 1;
    localparam int PIN_CAP2 = 2;
    localparam int PIN_N    = 3;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic rise_sel,
    output logic edge_o
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_t;

    sync_t d, q;
    logic  cur, prev;

    always_comb begin
        d    = q;
        d.sh = {q.sh[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cur    = q.sh[STAGES-1];
    assign prev   = q.sh[STAGES];
    assign edge_o = rise_sel ? (cur & ~prev) : (~cur & prev);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter bit HAS_EXT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       ext_edge,
    output logic       tick
);
    localparam int PRE_W = 3;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_t;

    pre_t d, q;

    always_comb begin
        d     = q;
        d.pre = q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (clk_sel_e'(sel))
            CK_DIV4: tick = &q.pre[1:0];
            CK_DIV2: tick = q.pre[0];
            CK_DIV8: tick = &q.pre[2:0];
            default: tick = HAS_EXT ? ext_edge : 1'b0;
        endcase
    end
endmodule

// File: rtl/cmp_timer16.sv
module cmp_timer16
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter bit HAS_EXT_CLK = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             ext_clk_in,
    input  logic             cap1_in,
    input  logic             cap2_in,
    output logic             out1_lvl,
    output logic             out1_en,
    output logic             out2_lvl,
    output logic             out2_en
);
    localparam int CTRL_W = 8;
    localparam int AUX_W  = 3;
    localparam int FLAG_W = 4;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [AUX_W-1:0]  aux;
        logic [CNT_W-1:0]  cmp1;
        logic [CNT_W-1:0]  cmp2;
        logic [CNT_W-1:0]  cap1;
        logic [CNT_W-1:0]  cap2;
        logic [CNT_W-1:0]  cnt;
        logic [FLAG_W-1:0] flags;
        logic              out1;
        logic              out2;
        logic              pulse;
    } st_t;

    st_t d, q;

    logic [PIN_N-1:0] pin_raw, pin_pol, pin_edge;
    logic tick, pwm_mode, opm_mode, trig, hit1, hit2, cap1_edge, cap2_edge;
    logic [FLAG_W-1:0] fl_set, fl_clr;

    assign pin_raw[PIN_EXT]  = ext_clk_in;
    assign pin_raw[PIN_CAP1] = cap1_in;
    assign pin_raw[PIN_CAP2] = cap2_in;
    assign pin_pol[PIN_EXT]  = q.ctrl[CB_EXPOL];
    assign pin_pol[PIN_CAP1] = q.aux[AX_C1POL];
    assign pin_pol[PIN_CAP2] = q.ctrl[CB_C2POL];

    for (genvar g = 0; g < PIN_N; g++) begin : g_pin
        tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .din      (pin_raw[g]),
            .rise_sel (pin_pol[g]),
            .edge_o   (pin_edge[g])
        );
    end

    assign cap1_edge = pin_edge[PIN_CAP1];
    assign cap2_edge = pin_edge[PIN_CAP2];

    tmr_prescale #(.HAS_EXT(HAS_EXT_CLK)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (q.ctrl[CB_CKHI:CB_CKLO]),
        .ext_edge (pin_edge[PIN_EXT]),
        .tick     (tick)
    );

    assign pwm_mode = q.ctrl[CB_PWM];
    assign opm_mode = q.ctrl[CB_OPM] & ~q.ctrl[CB_PWM];
    assign trig     = opm_mode & cap1_edge;
    assign hit1     = tick & (q.cnt == q.cmp1);
    assign hit2     = tick & (q.cnt == q.cmp2);

    always_comb begin
        d = q;

        // counter
        if (trig)                          d.cnt = '0;
        else if (tick && pwm_mode && hit2) d.cnt = '0;
        else if (tick)                     d.cnt = q.cnt + 1'b1;

        // output 1
        if (pwm_mode) begin
            d.pulse = 1'b0;
            if (hit2)      d.out1 = q.aux[AX_ACT];
            else if (hit1) d.out1 = q.aux[AX_IDLE];
        end else if (opm_mode) begin
            if (trig) begin
                d.out1  = q.aux[AX_ACT];
                d.pulse = 1'b1;
            end else if (q.pulse && hit1) begin
                d.out1  = q.aux[AX_IDLE];
                d.pulse = 1'b0;
            end
        end else begin
            d.pulse = 1'b0;
            if (hit1) d.out1 = q.aux[AX_ACT];
        end

        // output 2
        if (hit2) d.out2 = q.aux[AX_IDLE];

        // captures
        if (cap1_edge) d.cap1 = q.cnt;
        if (cap2_edge) d.cap2 = q.cnt;

        // flags
        fl_set          = '0;
        fl_set[FL_CAP1] = cap1_edge;
        fl_set[FL_CAP2] = cap2_edge;
        fl_set[FL_HIT1] = hit1;
        fl_set[FL_HIT2] = hit2;
        fl_clr          = (bus_wr && bus_addr == A_STAT) ? bus_wdata[FLAG_W-1:0] : '0;
        d.flags         = (q.flags & ~fl_clr) | fl_set;

        // register writes
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL:  d.ctrl = bus_wdata[CTRL_W-1:0];
                A_AUX:   d.aux  = bus_wdata[AUX_W-1:0];
                A_CMP1:  d.cmp1 = bus_wdata;
                A_CMP2:  d.cmp2 = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = CNT_W'(q.ctrl);
            A_AUX:   bus_rdata = CNT_W'(q.aux);
            A_CMP1:  bus_rdata = q.cmp1;
            A_CMP2:  bus_rdata = q.cmp2;
            A_CAP1:  bus_rdata = q.cap1;
            A_CAP2:  bus_rdata = q.cap2;
            A_CNT:   bus_rdata = q.cnt;
            default: bus_rdata = CNT_W'(q.flags);
        endcase
    end

    assign out1_lvl = q.out1;
    assign out2_lvl = q.out2;
    assign out1_en  = q.ctrl[CB_EN1];
    assign out2_en  = q.ctrl[CB_EN2];
endmodule

// File: rtl/cmp_timer16_chk.sv
module cmp_timer16_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             trig,
    input logic             cap2_edge,
    input logic             pwm,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp1,
    input logic [CNT_W-1:0] cmp2,
    input logic [CNT_W-1:0] cap2_reg,
    input logic             cap2_flag,
    input logic             out1,
    input logic             out2,
    input logic             lvl1,
    input logic             lvl2
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1) || cnt == '0)); // R3

    AST_OUT2_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == cmp2) |=> (out2 == $past(lvl2))); // R5

    AST_PWM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && tick && cnt == cmp2) |=> (cnt == '0 && out1 == $past(lvl1))); // R6

    AST_PWM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && tick && cnt == cmp1 && cnt != cmp2) |=> (out1 == $past(lvl2))); // R6

    AST_OPM_START: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cnt == '0 && out1 == $past(lvl1))); // R7

    AST_CAP2_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cap2_edge |=> (cap2_reg == $past(cnt) && cap2_flag)); // R8
endmodule

bind cmp_timer16 cmp_timer16_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .trig      (trig),
    .cap2_edge (cap2_edge),
    .pwm       (pwm_mode),
    .cnt       (q.cnt),
    .cmp1      (q.cmp1),
    .cmp2      (q.cmp2),
    .cap2_reg  (q.cap2),
    .cap2_flag (q.flags[1]),
    .out1      (q.out1),
    .out2      (q.out2),
    .lvl1      (q.aux[0]),
    .lvl2      (q.aux[1])
);

// File: tb/cmp_timer16_bench.sv
`timescale 1ns/1ps
module cmp_timer16_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd6;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_clk_in = 1'b0, cap1_in = 1'b0, cap2_in = 1'b0;
    logic        out1_lvl, out1_en, out2_lvl, out2_en;

    always #10 clk = ~clk;

    cmp_timer16 u_cmp_timer16 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_in(ext_clk_in),
        .cap1_in(cap1_in), .cap2_in(cap2_in), .out1_lvl(out1_lvl), .out1_en(out1_en),
        .out2_lvl(out2_lvl), .out2_en(out2_en)
    );

    int    n_cmp = 0, n_bad = 0, cyc = 0;
    string tag = "R1";

    // behavioural model state
    int m_ctrl, m_aux, m_cmp1, m_cmp2, m_cap1, m_cap2, m_cnt, m_flags, m_pc;
    bit m_o1, m_o2, m_pulse;
    bit hx[$], h1[$], h2[$];

    function automatic int m_read(int a);
        case (a)
            0: return m_ctrl;  1: return m_aux;
            2: return m_cmp1;  3: return m_cmp2;
            4: return m_cap1;  5: return m_cap2;
            6: return m_cnt;   default: return m_flags;
        endcase
    endfunction

    function automatic bit edge_of(bit s, bit p, bit rise);
        return rise ? (s && !p) : (!s && p);
    endfunction

    task automatic m_reset();
        m_ctrl = 0; m_aux = 0; m_cmp1 = 0; m_cmp2 = 0; m_cap1 = 0; m_cap2 = 0;
        m_cnt = 0; m_flags = 0; m_pc = 0; m_o1 = 0; m_o2 = 0; m_pulse = 0;
        hx = '{0, 0, 0}; h1 = '{0, 0, 0}; h2 = '{0, 0, 0};
    endtask

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else begin
            bit e_x, e_1, e_2, tk, pwm, opm, trig, hit1, hit2;
            int n_cnt, clr, setf, code;
            // samples from two and three edges back (R4)
            e_x = edge_of(hx[1], hx[0], m_ctrl[0]);
            e_1 = edge_of(h1[1], h1[0], m_aux[2]);
            e_2 = edge_of(h2[1], h2[0], m_ctrl[1]);
            hx.push_back(ext_clk_in); void'(hx.pop_front());
            h1.push_back(cap1_in);    void'(h1.pop_front());
            h2.push_back(cap2_in);    void'(h2.pop_front());
            code = (m_ctrl >> 2) & 3;
            case (code)
                0: tk = (m_pc % 4) == 3;
                1: tk = (m_pc % 2) == 1;
                2: tk = (m_pc % 8) == 7;
                default: tk = e_x;
            endcase
            m_pc = (m_pc + 1) % 8;
            pwm  = m_ctrl[4];
            opm  = m_ctrl[5] && !pwm;
            trig = opm && e_1;
            hit1 = tk && m_cnt == m_cmp1;
            hit2 = tk && m_cnt == m_cmp2;
            n_cnt = m_cnt;
            if (trig) n_cnt = 0;
            else if (tk && pwm && hit2) n_cnt = 0;
            else if (tk) n_cnt = (m_cnt + 1) & 16'hFFFF;
            if (pwm) begin
                m_pulse = 0;
                if (hit2) m_o1 = m_aux[0]; else if (hit1) m_o1 = m_aux[1];
            end else if (opm) begin
                if (trig) begin m_o1 = m_aux[0]; m_pulse = 1; end
                else if (m_pulse && hit1) begin m_o1 = m_aux[1]; m_pulse = 0; end
            end else begin
                m_pulse = 0;
                if (hit1) m_o1 = m_aux[0];
            end
            if (hit2) m_o2 = m_aux[1];
            if (e_1) m_cap1 = m_cnt;
            if (e_2) m_cap2 = m_cnt;
            setf = (e_1 ? 1 : 0) | (e_2 ? 2 : 0) | (hit1 ? 4 : 0) | (hit2 ? 8 : 0);
            clr  = (bus_wr && bus_addr == 7) ? (bus_wdata & 15) : 0;
            m_flags = (m_flags & ~clr) | setf;
            m_cnt = n_cnt;
            if (bus_wr) case (bus_addr)
                0: m_ctrl = bus_wdata & 8'hFF;
                1: m_aux  = bus_wdata & 7;
                2: m_cmp1 = bus_wdata;
                3: m_cmp2 = bus_wdata;
                default: ;
            endcase
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
        if (rst_n) begin
            chk(out1_lvl == m_o1, tag, "out1_lvl", out1_lvl, m_o1);
            chk(out2_lvl == m_o2, tag, "out2_lvl", out2_lvl, m_o2);
            chk(out1_en == m_ctrl[7], tag == "R1" ? "R1" : "R2", "out1_en", out1_en, m_ctrl[7]);
            chk(out2_en == m_ctrl[6], tag == "R1" ? "R1" : "R2", "out2_en", out2_en, m_ctrl[6]);
            chk(bus_rdata == m_read(bus_addr), tag, "rdata", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(int a, int v);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a[2:0]; bus_wdata = v[15:0];
        @(posedge clk); #2;
        bus_wr = 1'b0; bus_addr = 3'd6;
    endtask

    task automatic run(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic read_all();
        for (int a = 0; a < 8; a++) begin
            @(posedge clk); #2; bus_addr = a[2:0];
        end
        @(posedge clk); #2; bus_addr = 3'd6;
    endtask

    task automatic toggle_ext(int n, int gap);
        for (int i = 0; i < n; i++) begin
            run(gap); ext_clk_in = ~ext_clk_in;
        end
    endtask

    task automatic pulse_pin(int which, int width);
        @(posedge clk); #2;
        if (which == 1) cap1_in = 1'b1; else cap2_in = 1'b1;
        run(width);
        if (which == 1) cap1_in = 1'b0; else cap2_in = 1'b0;
    endtask

    initial begin
        m_reset();
        run(5);
        rst_n = 1'b1;
        // R1: reset values
        #1; chk(bus_rdata == 0, "R1", "counter after reset", bus_rdata, 0);
        chk(out1_lvl == 0 && out2_lvl == 0, "R1", "outputs after reset", out1_lvl, 0);
        read_all();

        // R10: map and read-only addresses
        tag = "R10";
        wr(2, 16'h1234); wr(3, 16'h00F0); wr(1, 3'b011);
        wr(4, 16'hFFFF); wr(5, 16'hFFFF); wr(6, 16'hFFFF);
        @(posedge clk); #2; bus_addr = 3'd2; #1;
        chk(bus_rdata == 16'h1234, "R10", "cmp1 readback", bus_rdata, 16'h1234);
        read_all();

        // R5: compare mode, /4 clock, both levels 1
        tag = "R5";
        wr(2, 40); wr(3, 70); wr(0, 8'hC0);
        run(320);
        read_all();

        // R3: clock codes /2, /8, external both polarities
        tag = "R3";
        wr(2, 16'h8000); wr(3, 16'h8001);
        wr(0, 8'hC4); run(40);
        wr(0, 8'hC8); run(60);
        wr(0, 8'hCD); toggle_ext(20, 3);
        wr(0, 8'hCC); toggle_ext(20, 4);

        // R4: single-cycle capture pulses show the sync delay
        tag = "R4";
        wr(0, 8'hC6);
        pulse_pin(2, 1); run(6); pulse_pin(2, 2); run(6);

        // R8: captures on both inputs, both polarities
        tag = "R8";
        wr(1, 3'b100); pulse_pin(1, 3); run(10);
        wr(1, 3'b000); pulse_pin(1, 3); run(10);
        wr(0, 8'hC4); pulse_pin(2, 5); run(10);
        bus_addr = 3'd4; run(3); bus_addr = 3'd5; run(3); bus_addr = 3'd7; run(3);

        // R9: write-one-to-clear of the flags
        tag = "R9";
        bus_addr = 3'd7;
        wr(7, 4'b0101); bus_addr = 3'd7; run(3);
        wr(7, 4'b1111); bus_addr = 3'd7; run(3);

        // R7: one-pulse, rising trigger, active 1 idle 0
        tag = "R7";
        wr(2, 10); wr(3, 16'hF000); wr(1, 3'b101); wr(0, 8'hA4);
        pulse_pin(1, 4); run(40);
        pulse_pin(1, 4); run(8); pulse_pin(1, 4); run(40);
        wr(1, 3'b001); cap1_in = 1'b1; run(10); cap1_in = 1'b0; run(40);

        // R6: PWM after a trigger restart keeps the count small
        tag = "R6";
        wr(1, 3'b101); wr(2, 6); wr(3, 40); pulse_pin(1, 3); run(6);
        wr(0, 8'hD4); wr(3, 14); run(200);
        wr(1, 3'b010); run(120);
        wr(2, 14); run(80);
        wr(2, 5); wr(0, 8'hF4); run(120);

        // R2: pin enables released, waveform continues
        tag = "R2";
        wr(1, 3'b101); wr(0, 8'h14); run(150);
        wr(0, 8'h44); run(60);
        read_all();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule